// File: doc/BRIEF.md
# Two-Strobe Transmit Word Buffer

This block is the staging buffer in front of a serial word transmitter. A host writes 31-bit words over a 16-bit parallel bus. Each word takes two bus strobes. The low strobe captures the lower sixteen bits and holds them. The high strobe supplies the upper fifteen bits and commits the complete word into an eight-entry first-in first-out store. A high strobe that arrives while the store is full is discarded, and the stored words are left unchanged. A high strobe that arrives with no low half waiting is rejected, and the block flags this with a one-cycle error pulse.

While transmit enable is high, the oldest stored word moves into an output register and is presented to the downstream serializer. The serializer acknowledges with a word-taken pulse, which retires the word and lets the next one move up in the same cycle. The ready flag goes high only when the store is empty and no word is still in flight. If transmit enable falls while a word is in flight, that word is discarded and is never sent.

Top module: `tx_word_buffer`

## Requirements
- R1: While reset is held, `tx_ready` is 1, `tx_word_valid` is 0 and `load_order_err` is 0.
- R2: A `load_lo_stb` pulse latches `bus_data[15:0]` as word bits [15:0]. A later `load_hi_stb` pulse appends `bus_data[14:0]` as word bits [30:16] and commits the word. `bus_data[15]` on the high strobe is ignored.
- R3: The store holds at most 8 words. Fullness is judged at the start of the cycle. A commit while 8 words are stored is dropped, and the stored words and their order are unchanged. The pending low half is consumed all the same.
- R4: A `load_hi_stb` with no pending low half writes nothing. In that case `load_order_err` is 1 during the following cycle only.
- R5: A cycle with both strobes high acts as a low strobe alone. It raises no error and commits nothing.
- R6: Words leave the block in the order they were committed.
- R7: While `tx_en` is 1 and the output register is empty or being taken, the oldest word moves out on the next edge. `tx_word_valid` is 1 from the following cycle, and `tx_word` holds steady until the word is taken.
- R8: A `word_taken` pulse while `tx_word_valid` and `tx_en` are 1 retires the word. The next stored word can appear in the very next cycle, so words can leave back to back.
- R9: `tx_ready` is 1 exactly when no committed word remains, either stored or in flight. It rises only in the cycle after a word in flight is retired or discarded.
- R10: If `tx_en` is 0 while a word is in flight, that word is discarded on the next edge and never sent again. The remaining stored words are kept.
- R11: While `tx_en` is 0, nothing leaves the store and `tx_word_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_data | input | 16 | Parallel load bus |
| load_lo_stb | input | 1 | First strobe: captures the low half |
| load_hi_stb | input | 1 | Second strobe: adds the high half and commits the word |
| tx_en | input | 1 | Transmit enable |
| word_taken | input | 1 | Serializer has taken the presented word |
| tx_word | output | 31 | Word presented to the serializer |
| tx_word_valid | output | 1 | `tx_word` holds a word in flight |
| tx_ready | output | 1 | All committed words have been sent |
| load_order_err | output | 1 | One-cycle pulse: high strobe without a low half |

## Verification
The bench builds the block with its default parameters: eight entries, a 31-bit word and a 16-bit bus. With only eight entries, the full-buffer drop path is reached after eight commits. The long randomized phase also wraps both store pointers many times, while pushes and pops collide in the same cycle. A 31-bit word assembled from a 16-bit bus leaves exactly one bus bit unused on the high strobe, so that bit can be set to show it is ignored.

// File: rtl/tx_buf_pkg.sv
package tx_buf_pkg;
  localparam int TXB_DEPTH  = 8;
  localparam int TXB_WORD_W = 31;
  localparam int TXB_BUS_W  = 16;
  localparam int TXB_LO_W   = 16;
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tx_word_assembler.sv
module tx_word_assembler #(
  parameter int BUS_W  = tx_buf_pkg::TXB_BUS_W,
  parameter int LO_W   = tx_buf_pkg::TXB_LO_W,
  parameter int WORD_W = tx_buf_pkg::TXB_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              ld_lo,
  input  logic              ld_hi,
  output logic              commit,
  output logic [WORD_W-1:0] commit_word,
  output logic              order_err
);
  localparam int HI_W = WORD_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic            pend_q, pend_d;
  logic            err_q, err_d;

  // next state: a low strobe wins over a simultaneous high strobe
  always_comb begin
    pend_d = pend_q;
    err_d  = 1'b0;
    commit = 1'b0;
    if (ld_lo) begin
      pend_d = 1'b1;
    end else if (ld_hi) begin
      if (pend_q) begin
        commit = 1'b1;
        pend_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  // low-half holding register, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (ld_lo) lo_q <= bus_data[LO_W-1:0];
  end

  assign commit_word = {bus_data[HI_W-1:0], lo_q};
  assign order_err   = err_q;
endmodule

// File: rtl/tx_word_store.sv
module tx_word_store #(
  parameter int DEPTH  = tx_buf_pkg::TXB_DEPTH,
  parameter int WORD_W = tx_buf_pkg::TXB_WORD_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic [CNT_W-1:0]  fill_cnt
);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d, wr_inc, rd_inc;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_en, rd_en;

  // fullness and emptiness are judged on the count at the start of the cycle
  assign wr_en = push && (cnt_q != CNT_W'(DEPTH));
  assign rd_en = pop && (cnt_q != '0);

  if (POW2) begin : g_wrap_free
    assign wr_inc = wr_q + 1'b1;
    assign rd_inc = rd_q + 1'b1;
  end else begin : g_wrap_cmp
    assign wr_inc = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    assign rd_inc = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
  end

  always_comb begin
    wr_d  = wr_en ? wr_inc : wr_q;
    rd_d  = rd_en ? rd_inc : rd_q;
    cnt_d = cnt_q;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_q] <= push_word;
  end

  assign head_word = mem_q[rd_q];
  assign fill_cnt  = cnt_q;
endmodule

// File: rtl/tx_word_launcher.sv
module tx_word_launcher #(
  parameter int WORD_W = tx_buf_pkg::TXB_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              word_taken,
  input  logic              store_empty,
  input  logic [WORD_W-1:0] head_word,
  output logic              pop,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid
);
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] word_q;
  logic              slot_free;

  assign slot_free = !valid_q || word_taken;
  assign pop       = tx_en && slot_free && !store_empty;

  // dropping the enable throws away the word in flight
  always_comb begin
    if (!tx_en)          valid_d = 1'b0;
    else if (pop)        valid_d = 1'b1;
    else if (word_taken) valid_d = 1'b0;
    else                 valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (pop) word_q <= head_word;
  end

  assign out_word  = word_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/tx_word_buffer.sv
module tx_word_buffer #(
  parameter int DEPTH  = tx_buf_pkg::TXB_DEPTH,
  parameter int WORD_W = tx_buf_pkg::TXB_WORD_W,
  parameter int BUS_W  = tx_buf_pkg::TXB_BUS_W,
  parameter int LO_W   = tx_buf_pkg::TXB_LO_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              load_lo_stb,
  input  logic              load_hi_stb,
  input  logic              tx_en,
  input  logic              word_taken,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_word_valid,
  output logic              tx_ready,
  output logic              load_order_err
);
  logic              core_rst_n;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] head_word;
  logic [CNT_W-1:0]  fill_cnt;
  logic              store_empty;
  logic              pop;

  tx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  tx_word_assembler #(.BUS_W(BUS_W), .LO_W(LO_W), .WORD_W(WORD_W)) u_asm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .bus_data    (bus_data),
    .ld_lo       (load_lo_stb),
    .ld_hi       (load_hi_stb),
    .commit      (commit),
    .commit_word (commit_word),
    .order_err   (load_order_err)
  );

  tx_word_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .push      (commit),
    .push_word (commit_word),
    .pop       (pop),
    .head_word (head_word),
    .fill_cnt  (fill_cnt)
  );

  assign store_empty = (fill_cnt == '0);

  tx_word_launcher #(.WORD_W(WORD_W)) u_launch (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .tx_en       (tx_en),
    .word_taken  (word_taken),
    .store_empty (store_empty),
    .head_word   (head_word),
    .pop         (pop),
    .out_word    (tx_word),
    .out_valid   (tx_word_valid)
  );

  // the word count covers the store and the word in flight
  assign tx_ready = store_empty && !tx_word_valid;
endmodule

// File: rtl/tx_word_buffer_chk.sv
module tx_word_buffer_chk #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 31,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_lo_stb,
  input logic              load_hi_stb,
  input logic              tx_en,
  input logic              word_taken,
  input logic [WORD_W-1:0] tx_word,
  input logic              tx_word_valid,
  input logic              tx_ready,
  input logic              load_order_err,
  input logic [CNT_W-1:0]  fill_cnt
);
  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_order_err |-> $past(load_hi_stb && !load_lo_stb));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CNT_W'(DEPTH)) |=> (fill_cnt >= CNT_W'(DEPTH - 1)));

  p_ready_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(tx_word_valid));

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_valid && tx_en && !word_taken) |=> (tx_word_valid && $stable(tx_word)));

  p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_valid && !tx_en) |=> !tx_word_valid);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_word_valid);
endmodule

bind tx_word_buffer tx_word_buffer_chk #(
  .DEPTH (DEPTH),
  .WORD_W(WORD_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (core_rst_n),
  .load_lo_stb    (load_lo_stb),
  .load_hi_stb    (load_hi_stb),
  .tx_en          (tx_en),
  .word_taken     (word_taken),
  .tx_word        (tx_word),
  .tx_word_valid  (tx_word_valid),
  .tx_ready       (tx_ready),
  .load_order_err (load_order_err),
  .fill_cnt       (fill_cnt)
);

// File: tb/tb_tx_word_buffer.sv
module tb_tx_word_buffer;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_data;
  logic        load_lo_stb, load_hi_stb, tx_en, word_taken;
  logic [30:0] tx_word;
  logic        tx_word_valid, tx_ready, load_order_err;

  always #10 clk = ~clk;

  tx_word_buffer dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
    .load_lo_stb(load_lo_stb), .load_hi_stb(load_hi_stb),
    .tx_en(tx_en), .word_taken(word_taken),
    .tx_word(tx_word), .tx_word_valid(tx_word_valid),
    .tx_ready(tx_ready), .load_order_err(load_order_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [30:0] mq[$];
  logic [15:0] m_lo;
  bit          m_pend, m_valid, m_err;
  logic [30:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_pend = 0; m_valid = 0; m_err = 0;
    end else begin
      int s;
      s = mq.size();
      if (!tx_en) m_valid = 0;
      else begin
        if (m_valid && word_taken) m_valid = 0;
        if (!m_valid && s > 0) begin
          m_word = mq.pop_front();
          m_valid = 1;
        end
      end
      m_err = 0;
      if (load_lo_stb) begin
        m_lo = bus_data; m_pend = 1;
      end else if (load_hi_stb) begin
        if (m_pend) begin
          if (s < DEPTH) mq.push_back({bus_data[14:0], m_lo});
          m_pend = 0;
        end else m_err = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R9 tx_ready model", 32'(tx_ready), 32'(mq.size() == 0 && !m_valid));
      check("R7 tx_word_valid model", 32'(tx_word_valid), 32'(m_valid));
      if (m_valid) check("R6 tx_word model", 32'(tx_word), 32'(m_word));
      check("R4 load_order_err model", 32'(load_order_err), 32'(m_err));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic strobe_lo(logic [15:0] d);
    bus_data = d; load_lo_stb = 1; step(); load_lo_stb = 0;
  endtask

  task automatic strobe_hi(logic [15:0] d);
    bus_data = d; load_hi_stb = 1; step(); load_hi_stb = 0;
  endtask

  task automatic load_word(logic [15:0] lo, logic [15:0] hi);
    strobe_lo(lo);
    strobe_hi(hi);
  endtask

  function automatic logic [30:0] wrd(logic [15:0] lo, logic [15:0] hi);
    return {hi[14:0], lo};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_data = '0; load_lo_stb = 0; load_hi_stb = 0;
    tx_en = 0; word_taken = 0;
    #5;
    check("R1 ready in reset", 32'(tx_ready), 32'd1);
    check("R1 valid in reset", 32'(tx_word_valid), 32'd0);
    check("R1 err in reset", 32'(load_order_err), 32'd0);
    step(3);
    rst_n = 1;
    step(4);
    cmp_on = 1;

    // R2: assembly and unused bus bit 15 on the high strobe
    load_word(16'hA5A5, 16'hFFFF);
    check("R9 ready low after commit", 32'(tx_ready), 32'd0);
    tx_en = 1;
    step();
    check("R2 valid", 32'(tx_word_valid), 32'd1);
    check("R2 assembled word", 32'(tx_word), 32'h7FFFA5A5);
    word_taken = 1;
    step();
    check("R8 retired", 32'(tx_word_valid), 32'd0);
    check("R9 ready after last", 32'(tx_ready), 32'd1);
    word_taken = 0; tx_en = 0;

    // R3: nine loads with enable off, ninth dropped
    for (int i = 0; i < 9; i++) load_word(16'h1000 + 16'(i), 16'h0200 + 16'(i));
    step(2);
    check("R11 no launch while disabled", 32'(tx_word_valid), 32'd0);
    check("R9 ready low with stored words", 32'(tx_ready), 32'd0);
    tx_en = 1; word_taken = 1;
    for (int k = 0; k < 8; k++) begin
      step();
      check("R6 order", 32'(tx_word), 32'(wrd(16'h1000 + 16'(k), 16'h0200 + 16'(k))));
      check("R8 back to back valid", 32'(tx_word_valid), 32'd1);
    end
    step();
    check("R3 ninth word dropped", 32'(tx_word_valid), 32'd0);
    check("R3 ready after eight", 32'(tx_ready), 32'd1);
    tx_en = 0; word_taken = 0;

    // R4: orphan high strobe
    strobe_hi(16'h1234);
    check("R4 err pulse", 32'(load_order_err), 32'd1);
    step();
    check("R4 err one cycle", 32'(load_order_err), 32'd0);
    check("R4 nothing written", 32'(tx_ready), 32'd1);

    // R5: both strobes together act as a low strobe
    bus_data = 16'hBEEF; load_lo_stb = 1; load_hi_stb = 1;
    step();
    load_lo_stb = 0; load_hi_stb = 0;
    check("R5 no commit", 32'(tx_ready), 32'd1);
    step();
    check("R5 no error", 32'(load_order_err), 32'd0);
    strobe_hi(16'h0123);
    check("R5 high accepted", 32'(load_order_err), 32'd0);
    tx_en = 1;
    step();
    check("R5 word", 32'(tx_word), 32'h0123BEEF);
    step(2);
    check("R7 held until taken", 32'(tx_word), 32'h0123BEEF);
    word_taken = 1;
    step();
    word_taken = 0; tx_en = 0;
    check("R9 ready", 32'(tx_ready), 32'd1);

    // R10: enable dropped with a word in flight
    load_word(16'h0011, 16'h0022);
    load_word(16'h0033, 16'h0044);
    tx_en = 1;
    step();
    check("R10 first in flight", 32'(tx_word), 32'h00220011);
    tx_en = 0;
    step();
    check("R10 discarded", 32'(tx_word_valid), 32'd0);
    check("R10 remaining kept", 32'(tx_ready), 32'd0);
    step(3);
    check("R11 idle", 32'(tx_word_valid), 32'd0);
    tx_en = 1; word_taken = 1;
    step();
    check("R10 next word is second", 32'(tx_word), 32'h00440033);
    step();
    check("R10 ready after second", 32'(tx_ready), 32'd1);

    // mixed traffic compared against the model every clock
    for (int i = 0; i < 3000; i++) begin
      bus_data    = 16'($urandom);
      load_lo_stb = ($urandom % 4) == 0;
      load_hi_stb = ($urandom % 3) == 0;
      tx_en       = ($urandom % 16) != 0;
      word_taken  = ($urandom % 3) != 0;
      step();
    end
    load_lo_stb = 0; load_hi_stb = 0; tx_en = 1; word_taken = 1;
    step(20);
    check("R9 drained", 32'(tx_ready), 32'd1);

    done = 1;
    summary();
    $finish;
  end
endmodule